// File: doc/BRIEF.md
# Host Word Read Transfer Engine

This block streams the contents of a 16 KiB byte buffer out to a host, one 16-bit word per read strobe. Before a transfer, software loads a 16-bit byte count and a 16-bit data address one byte at a time. It also writes an interface-control byte whose output-enable bit permits transfers. A trigger strobe then arms the engine. When the destination code selects one of the two host-read paths, the engine opens its data window and raises a ready bit. Each accepted read fetches the word at the current even address. It then advances the address and lowers the count by two.

The transfer ends on the read that takes the count, seen as a signed 16-bit number, to zero or below. At that point the engine closes its data window and drops its busy state. It lowers an active-low transfer-end flag and marks the count's top nibble with ones. A dedicated acknowledge strobe releases the flag and removes the marker. An interrupt request follows the pending flag while the interrupt-enable input is high. The buffer itself sits outside the block behind a synchronous read port.

Top module: `hrx_engine`

## Requirements
- R1: After reset, byte_cnt and data_addr are 0, busy_n, den_n and dte_n are 1, host_stat bits 7 and 6 are 0, rd_valid and irq are 0.
- R2: A trigger while the stored output-enable bit (reg_wdata bit 1 of the last interface-control write) is 1 drives busy_n to 0, clears byte_cnt bits 15:12 and clears host_stat bits 7 and 6. A trigger while that bit is 0 changes nothing.
- R3: An accepted trigger with dest_sel equal to 2 or 3 also drives den_n to 0 and sets host_stat bit 6 (ready). Any other code leaves den_n at 1 and ready at 0.
- R4: A read accepted while den_n is 0 puts mem_addr = data_addr AND 0x3FFE with mem_re high. In the next cycle rd_valid is 1 and rd_data carries the byte at that address in bits 15:8 and the byte at the next address in bits 7:0.
- R5: Each accepted read adds 2 to data_addr and subtracts 2 from byte_cnt (16-bit wrap).
- R6: When byte_cnt minus 2, as a signed 16-bit value, is zero or less on an accepted read, busy_n and den_n go to 1, dte_n goes to 0, and byte_cnt takes the decremented value with bits 15:12 forced to 1.
- R7: At that transfer end host_stat bit 6 clears and bit 7 (end) sets. host_stat bits 2:0 always show dest_sel.
- R8: An acknowledge strobe returns dte_n to 1 and clears byte_cnt bits 15:12.
- R9: An interface-control write with reg_wdata bit 1 at 0 sets busy_n and den_n to 1, ending any transfer without raising dte_n low.
- R10: A read while den_n is 1 leaves byte_cnt, data_addr and the flags unchanged, keeps mem_re low and gives rd_valid 0 next cycle.
- R11: irq is 1 exactly while dte_n is 0 and irq_en is 1. dte_n stays 0 until an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ictl_we | input | 1 | Interface-control write strobe (bit 1 of reg_wdata = output enable) |
| cnt_lo_we | input | 1 | Write reg_wdata into byte count bits 7:0 |
| cnt_hi_we | input | 1 | Write reg_wdata into byte count bits 15:8 |
| addr_lo_we | input | 1 | Write reg_wdata into data address bits 7:0 |
| addr_hi_we | input | 1 | Write reg_wdata into data address bits 15:8 |
| reg_wdata | input | 8 | Shared register write byte |
| dest_sel | input | 3 | Transfer destination code |
| irq_en | input | 1 | Transfer-end interrupt enable |
| trig | input | 1 | Transfer trigger strobe |
| ack | input | 1 | Transfer-end acknowledge strobe |
| rd | input | 1 | Host word read strobe |
| rd_data | output | 16 | Word returned for the previous accepted read |
| rd_valid | output | 1 | rd_data is valid |
| mem_re | output | 1 | Buffer read enable |
| mem_addr | output | 14 | Even buffer byte address |
| mem_rdata | input | 16 | Buffer word, registered one cycle after mem_re |
| byte_cnt | output | 16 | Byte count register |
| data_addr | output | 16 | Data address register |
| busy_n | output | 1 | Low while a transfer is armed |
| den_n | output | 1 | Low while host reads are accepted |
| dte_n | output | 1 | Low while a transfer end is pending |
| host_stat | output | 8 | Bit 7 end, bit 6 ready, bits 2:0 destination code |
| irq | output | 1 | Transfer-end interrupt request |

## Verification
A wrong end test shows up on the final read of a transfer. The read after it is still accepted, or the transfer stops one word early, and den_n, dte_n and the count marker are off by one word. A wrong address or count step changes rd_data, byte_cnt or data_addr in the cycle right after the faulty read. A wrong acknowledge or abort path leaves dte_n, irq or busy_n visibly stuck. A read that is not gated shows as a changed count while den_n is high.

// File: rtl/hrx_pkg.sv
// Shared constants and helpers for the host word read engine.
// Assumes 16-bit count and address registers written one byte at a time.
package hrx_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 2 * BYTE_W;
    localparam int OE_BIT = 1;
    typedef logic [2:0] dest_t;

    // True for the two destination codes that route data to the host.
    function automatic logic is_host_dest(input dest_t d);
        return (d == 3'd2) || (d == 3'd3);
    endfunction
endpackage

// File: rtl/hrx_ictl.sv
// Interface-control holder: keeps the output-enable bit and flags an abort
// whenever a control write clears it. Assumes one write strobe per cycle.
module hrx_ictl (
    input  logic clk,
    input  logic rst_n,
    input  logic ictl_we,
    input  logic oe_bit,
    output logic out_en,
    output logic abort
);
    assign abort = ictl_we && !oe_bit;

    // Capture the output-enable bit on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_en <= 1'b0;
        else if (ictl_we) out_en <= oe_bit;
    end

    a_r9_abort_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !out_en);
endmodule

// File: rtl/hrx_counters.sv
// Byte count and data address registers. Byte writes win over engine updates;
// reads step both by two, and the end marker is applied on the last word.
module hrx_counters #(
    parameter int MARK_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cnt_lo_we,
    input  logic                       cnt_hi_we,
    input  logic                       addr_lo_we,
    input  logic                       addr_hi_we,
    input  logic [hrx_pkg::BYTE_W-1:0] wdata,
    input  logic                       trig_go,
    input  logic                       ack,
    input  logic                       rd_go,
    output logic [hrx_pkg::REG_W-1:0]  cnt,
    output logic [hrx_pkg::REG_W-1:0]  addr,
    output logic                       last_word
);
    import hrx_pkg::*;
    localparam int LOW_W = REG_W - MARK_W;

    logic [REG_W-1:0] cnt_nxt;
    logic             any_we;

    assign cnt_nxt   = cnt - REG_W'(2);
    assign last_word = ($signed(cnt_nxt) <= $signed({REG_W{1'b0}}));
    assign any_we    = cnt_lo_we || cnt_hi_we || addr_lo_we || addr_hi_we;

    // Update count and address; later statements take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            addr <= '0;
        end else begin
            if (rd_go) begin
                addr <= addr + REG_W'(2);
                cnt  <= last_word ? {{MARK_W{1'b1}}, cnt_nxt[LOW_W-1:0]} : cnt_nxt;
            end
            if (trig_go || ack) cnt[REG_W-1 -: MARK_W] <= '0;
            if (cnt_lo_we)  cnt[BYTE_W-1:0]      <= wdata;
            if (cnt_hi_we)  cnt[REG_W-1:BYTE_W]  <= wdata;
            if (addr_lo_we) addr[BYTE_W-1:0]     <= wdata;
            if (addr_hi_we) addr[REG_W-1:BYTE_W] <= wdata;
        end
    end

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !any_we) |=> addr == $past(addr) + REG_W'(2));
    a_r6_marker_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && last_word && !any_we && !trig_go && !ack) |=> cnt[REG_W-1 -: MARK_W] == {MARK_W{1'b1}});
    a_r8_marker_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !any_we && !rd_go) |=> cnt[REG_W-1 -: MARK_W] == '0);
endmodule

// File: rtl/hrx_flags.sv
// Transfer state flags: busy, data enable, transfer end, ready and end bits.
// Assumes trigger and final read do not coincide; abort has top priority.
module hrx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_go,
    input  logic host_dest,
    input  logic end_hit,
    input  logic ack,
    input  logic abort,
    output logic busy_n,
    output logic den_n,
    output logic dte_n,
    output logic rdy,
    output logic eot
);
    // Sequence the flags through arm, end, acknowledge and abort events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_n <= 1'b1;
            den_n  <= 1'b1;
            dte_n  <= 1'b1;
            rdy    <= 1'b0;
            eot    <= 1'b0;
        end else begin
            if (trig_go) begin
                busy_n <= 1'b0;
                eot    <= 1'b0;
                rdy    <= host_dest;
                if (host_dest) den_n <= 1'b0;
            end
            if (end_hit) begin
                busy_n <= 1'b1;
                den_n  <= 1'b1;
                dte_n  <= 1'b0;
                rdy    <= 1'b0;
                eot    <= 1'b1;
            end
            if (ack) dte_n <= 1'b1;
            if (abort) begin
                busy_n <= 1'b1;
                den_n  <= 1'b1;
            end
        end
    end

    a_r3_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_go && host_dest && !abort && !end_hit) |=> (!den_n && rdy));
    a_r6_end_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (end_hit && !trig_go && !ack) |=> (busy_n && den_n && !dte_n));
    a_r7_end_status: assert property (@(posedge clk) disable iff (!rst_n)
        (end_hit && !trig_go) |=> (eot && !rdy));
    a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> dte_n);
    a_r11_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dte_n && !ack) |=> !dte_n);
endmodule

// File: rtl/hrx_engine.sv
// Host word read engine top: joins control, counters and flags, gates host
// reads by the data window and returns buffer words one cycle after a read.
// Assumes the buffer read port registers its word on the mem_re edge.
module hrx_engine #(
    parameter int BUF_AW = 14,
    parameter int MARK_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ictl_we,
    input  logic                       cnt_lo_we,
    input  logic                       cnt_hi_we,
    input  logic                       addr_lo_we,
    input  logic                       addr_hi_we,
    input  logic [hrx_pkg::BYTE_W-1:0] reg_wdata,
    input  logic [2:0]                 dest_sel,
    input  logic                       irq_en,
    input  logic                       trig,
    input  logic                       ack,
    input  logic                       rd,
    output logic [hrx_pkg::REG_W-1:0]  rd_data,
    output logic                       rd_valid,
    output logic                       mem_re,
    output logic [BUF_AW-1:0]          mem_addr,
    input  logic [hrx_pkg::REG_W-1:0]  mem_rdata,
    output logic [hrx_pkg::REG_W-1:0]  byte_cnt,
    output logic [hrx_pkg::REG_W-1:0]  data_addr,
    output logic                       busy_n,
    output logic                       den_n,
    output logic                       dte_n,
    output logic [hrx_pkg::BYTE_W-1:0] host_stat,
    output logic                       irq
);
    import hrx_pkg::*;

    logic out_en, abort, trig_go, rd_go, last_word, end_hit, rdy, eot;

    assign trig_go = trig && out_en;
    assign rd_go   = rd && !den_n;
    assign end_hit = rd_go && last_word;

    hrx_ictl u_ictl (
        .clk(clk), .rst_n(rst_n), .ictl_we(ictl_we),
        .oe_bit(reg_wdata[OE_BIT]), .out_en(out_en), .abort(abort)
    );

    hrx_counters #(.MARK_W(MARK_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we),
        .addr_lo_we(addr_lo_we), .addr_hi_we(addr_hi_we),
        .wdata(reg_wdata), .trig_go(trig_go), .ack(ack), .rd_go(rd_go),
        .cnt(byte_cnt), .addr(data_addr), .last_word(last_word)
    );

    hrx_flags u_flags (
        .clk(clk), .rst_n(rst_n), .trig_go(trig_go),
        .host_dest(is_host_dest(dest_sel)), .end_hit(end_hit),
        .ack(ack), .abort(abort),
        .busy_n(busy_n), .den_n(den_n), .dte_n(dte_n), .rdy(rdy), .eot(eot)
    );

    assign mem_re    = rd_go;
    assign mem_addr  = {data_addr[BUF_AW-1:1], 1'b0};
    assign rd_data   = rd_valid ? mem_rdata : '0;
    assign host_stat = {eot, rdy, 3'b000, dest_sel};
    assign irq       = !dte_n && irq_en;

    // Mark the cycle in which the buffer word for an accepted read is present.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_go;
    end

    a_r10_gated_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && den_n && !trig && !ack && !ictl_we && !cnt_lo_we && !cnt_hi_we
         && !addr_lo_we && !addr_hi_we) |=> ($stable(byte_cnt) && $stable(data_addr) && !rd_valid));
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> rd_valid);
endmodule

// File: tb/sim_hrx_engine.sv
// Bench for hrx_engine: table-driven host transfers, then directed corners.
module sim_hrx_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // Each entry: {start count, start address, destination code}
    localparam logic [34:0] VEC [NVEC] = '{
        {16'h0004, 16'h0000, 3'd2},
        {16'h0005, 16'h0101, 3'd3},
        {16'hA003, 16'h3FFC, 3'd2},
        {16'h0000, 16'h7FF0, 3'd3},
        {16'h0008, 16'h1234, 3'd2}
    };

    logic clk = 0, rst_n = 0;
    logic ictl_we = 0, cnt_lo_we = 0, cnt_hi_we = 0, addr_lo_we = 0, addr_hi_we = 0;
    logic [7:0] reg_wdata = 0;
    logic [2:0] dest_sel = 0;
    logic irq_en = 0, trig = 0, ack = 0, rd = 0;
    logic [15:0] rd_data, mem_rdata, byte_cnt, data_addr;
    logic rd_valid, mem_re, busy_n, den_n, dte_n, irq;
    logic [13:0] mem_addr;
    logic [7:0] host_stat;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hrx_engine u0 (.*);

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 5) ^ (a >> 6) ^ 8'h3C);
    endfunction

    // Synchronous byte buffer model with computed content.
    always_ff @(posedge clk)
        if (mem_re) mem_rdata <= {pat(int'(mem_addr)), pat(int'(mem_addr) + 1)};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic wreg(input int sel, input logic [7:0] v);
        reg_wdata = v;
        case (sel)
            0: ictl_we = 1;
            1: cnt_lo_we = 1;
            2: cnt_hi_we = 1;
            3: addr_lo_we = 1;
            default: addr_hi_we = 1;
        endcase
        tick();
        {ictl_we, cnt_lo_we, cnt_hi_we, addr_lo_we, addr_hi_we} = '0;
    endtask

    task automatic pulse_trig; trig = 1; tick(); trig = 0; endtask
    task automatic pulse_ack;  ack = 1;  tick(); ack = 0;  endtask
    task automatic pulse_rd;   rd = 1;   tick(); rd = 0;   endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1; #1;
        // R1: reset state
        chk("R1 cnt", byte_cnt, 0);
        chk("R1 addr", data_addr, 0);
        chk("R1 flags", {busy_n, den_n, dte_n, rd_valid, irq}, 5'b11100);
        chk("R1 stat", host_stat[7:6], 0);

        // R2: trigger with output enable off is ignored
        dest_sel = 3'd2;
        pulse_trig();
        chk("R2 ignored", {busy_n, den_n, host_stat[6]}, 3'b110);

        // Table: full host transfers
        irq_en = 1;
        for (int v = 0; v < NVEC; v++) begin
            automatic logic [15:0] c0 = VEC[v][34:19];
            automatic logic [15:0] a0 = VEC[v][18:3];
            automatic int c = int'(c0 & 16'h0FFF);
            automatic int w = (c == 0) ? 1 : (c + 1) / 2;
            automatic logic [15:0] cend = 16'(c - 2 * w);
            dest_sel = VEC[v][2:0];
            wreg(1, c0[7:0]); wreg(2, c0[15:8]);
            wreg(3, a0[7:0]); wreg(4, a0[15:8]);
            wreg(0, 8'h02);
            pulse_trig();
            chk("R2 armed", {busy_n, byte_cnt[15:12], host_stat[7]}, 6'b0_0000_0);
            chk("R3 window", {den_n, host_stat[6]}, 2'b01);
            for (int k = 0; k < w; k++) begin
                automatic int ea = int'((a0 + 16'(2 * k)) & 16'h3FFE);
                pulse_rd();
                chk("R4 data", {rd_valid, rd_data}, {1'b1, pat(ea), pat(ea + 1)});
                if (k < w - 1)
                    chk("R5 step", {byte_cnt, data_addr},
                        {16'(c - 2 * (k + 1)), a0 + 16'(2 * (k + 1))});
            end
            chk("R5 addr end", data_addr, a0 + 16'(2 * w));
            chk("R6 end", {busy_n, den_n, dte_n, byte_cnt},
                {3'b110, (cend & 16'h0FFF) | 16'hF000});
            chk("R7 stat", host_stat, {2'b10, 3'b000, VEC[v][2:0]});
            chk("R11 irq", irq, 1);
            pulse_rd();
            chk("R10 after end", {rd_valid, data_addr}, {1'b0, a0 + 16'(2 * w)});
            tick();
            chk("R11 held", {dte_n, irq}, 2'b01);
            pulse_ack();
            chk("R8 ack", {dte_n, irq, byte_cnt[15:12]}, 6'b10_0000);
        end

        // R3: non-host destination keeps the window closed; R10 reads ignored
        wreg(1, 8'h10); wreg(2, 8'h00);
        dest_sel = 3'd5;
        pulse_trig();
        chk("R3 other dest", {busy_n, den_n, host_stat[6]}, 3'b010);
        pulse_rd();
        chk("R10 ignored", {rd_valid, mem_re, byte_cnt}, {2'b00, 16'h0010});
        // R9: abort
        wreg(0, 8'h00);
        chk("R9 abort busy", {busy_n, den_n, dte_n}, 3'b111);

        // R9: abort mid host transfer, then R2 trigger ignored while disabled
        wreg(0, 8'h02);
        dest_sel = 3'd3;
        pulse_trig();
        pulse_rd();
        wreg(0, 8'h00);
        chk("R9 abort window", {busy_n, den_n, dte_n, byte_cnt}, {3'b111, 16'h000E});
        pulse_trig();
        chk("R2 disabled", {busy_n, den_n}, 2'b11);

        // R11: end with interrupt disabled
        irq_en = 0;
        wreg(0, 8'h02);
        wreg(1, 8'h02); wreg(2, 8'h00);
        pulse_trig();
        pulse_rd();
        chk("R11 masked", {dte_n, irq}, 2'b00);
        irq_en = 1; #1;
        chk("R11 unmasked", irq, 1);
        pulse_ack();
        chk("R8 ack2", {dte_n, irq}, 2'b10);

        // R1: reset again mid transfer
        pulse_trig();
        rst_n = 0; tick(); rst_n = 1; #1;
        chk("R1 rereset", {busy_n, den_n, dte_n, byte_cnt}, {3'b111, 16'h0000});

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule